// File: doc/BRIEF.md
# Load Effective Address Generator

This unit forms the memory address for the fixed-point load instructions of a 64-bit processor. Each cycle it may receive one request: a base register index and its contents, an index register value, a displacement field, an addressing-form select, an update flag and a target register index. It chooses the base term, shapes the displacement or takes the index value, adds the two, and checks the request for register combinations that make the instruction form invalid.

The sum wraps modulo 2^64. The address, the invalid-form flag and, for update forms, a writeback request that carries the address back to the base register appear on registered outputs one cycle after the request strobe. Memory access, data formatting and exception delivery belong to other blocks.

Top module: `load_ea_unit`

## Requirements
- R1: After reset, `out_valid`, `wb_en` and `bad_form` are 0 and `ea` is zero.
- R2: When `upd` is 0 and `base_idx` is 0, the base term is zero and `base_val` has no effect on `ea`.
- R3: When `upd` is 1, the base term is `base_val` even when `base_idx` is 0.
- R4: Indexed form (`form_sel` = 3) gives `ea` = base term + `idx_val`, with all 64 bits of `idx_val` used.
- R5: Form D (`form_sel` = 0) adds all 16 bits of `disp`, sign-extended to 64 bits.
- R6: Form DS (`form_sel` = 1) takes `disp[13:0]`, sign-extends it and shifts it left by 2, so the offset is a multiple of 4 and `disp[15:14]` is ignored.
- R7: Form DQ (`form_sel` = 2) takes `disp[11:0]`, sign-extends it and shifts it left by 4, so the offset is a multiple of 16 and `disp[15:12]` is ignored.
- R8: Form DQ is the register-pair load. `bad_form` is 1 when `tgt_idx` is odd or equals `base_idx`.
- R9: An update request with `base_idx` equal to 0 or equal to `tgt_idx` sets `bad_form`, and `wb_en` stays 0.
- R10: A valid update request raises `wb_en` for one cycle, with `wb_idx` = `base_idx` and `wb_data` = `ea`.
- R11: The addition wraps modulo 2^64. There is no carry or overflow output.
- R12: Outputs update on the first rising edge after `in_valid` is sampled high, and `out_valid` pulses with them. While `in_valid` is low, `out_valid` and `wb_en` are 0 and `ea` and `bad_form` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| form_sel | input | 2 | Form: 0 D, 1 DS, 2 DQ, 3 indexed |
| upd | input | 1 | Update form: write the address back to the base register |
| base_idx | input | 5 | Base register index |
| base_val | input | 64 | Base register contents |
| idx_val | input | 64 | Index register contents |
| disp | input | 16 | Displacement field, right-aligned |
| tgt_idx | input | 5 | Target register index |
| out_valid | output | 1 | Result strobe |
| ea | output | 64 | Effective address |
| bad_form | output | 1 | Invalid instruction form |
| wb_en | output | 1 | Base register writeback request |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 64 | Writeback value (the address) |

## Verification
The bench targets these corner cases and the failure each one exposes:
- Base index 0 in both update and non-update requests. A design that skips the zero substitution, or applies it to update forms, adds the wrong base.
- Negative displacements in every form, with garbage in the field's unused upper bits. A design that sign-extends from the wrong bit, or shifts by the wrong amount, returns an address that is off by a large or a misaligned value.
- Register pairs that are odd or that overlap the base register, and update requests that name register 0 or the target register. A design that misses these leaves `bad_form` low or raises a writeback.
- An index sum that overflows, and idle cycles after a request. A wrong design drops the wrap or lets the outputs drift while the strobe is low.

// File: rtl/lea_pkg.sv
package lea_pkg;
  typedef enum logic [1:0] {
    FORM_D  = 2'd0,
    FORM_DS = 2'd1,
    FORM_DQ = 2'd2,
    FORM_X  = 2'd3
  } form_e;
endpackage

// File: rtl/lea_offset.sv
module lea_offset #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16
) (
  input  lea_pkg::form_e    form,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   idx_val,
  output logic [XLEN-1:0]   offset
);
  localparam int DS_W = DISP_W - 2;
  localparam int DQ_W = DISP_W - 4;

  // Sign-extend the low w bits of f to XLEN bits.
  function automatic logic [XLEN-1:0] sext_low(input logic [DISP_W-1:0] f, input int w);
    logic [XLEN-1:0] t;
    t = XLEN'(f) << (XLEN - w);
    return XLEN'($signed(t) >>> (XLEN - w));
  endfunction

  always_comb begin
    unique case (form)
      lea_pkg::FORM_D:  offset = sext_low(disp, DISP_W);
      lea_pkg::FORM_DS: offset = sext_low(disp, DS_W) << 2;
      lea_pkg::FORM_DQ: offset = sext_low(disp, DQ_W) << 4;
      default:          offset = idx_val;
    endcase
  end
endmodule

// File: rtl/lea_base_sel.sv
module lea_base_sel #(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5
) (
  input  logic              upd,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [XLEN-1:0]   base_val,
  output logic [XLEN-1:0]   base_term,
  output logic              zero_sub
);
  // Register 0 reads as zero, except in update forms.
  assign zero_sub  = !upd && (base_idx == '0);
  assign base_term = zero_sub ? '0 : base_val;
endmodule

// File: rtl/lea_form_check.sv
module lea_form_check #(
  parameter int RIDX_W = 5
) (
  input  lea_pkg::form_e    form,
  input  logic              upd,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [RIDX_W-1:0] tgt_idx,
  output logic              pair_bad,
  output logic              upd_bad,
  output logic              bad
);
  assign pair_bad = (form == lea_pkg::FORM_DQ) && (tgt_idx[0] || (tgt_idx == base_idx));
  assign upd_bad  = upd && ((base_idx == '0) || (base_idx == tgt_idx));
  assign bad      = pair_bad || upd_bad;
endmodule

// File: rtl/lea_out_reg.sv
module lea_out_reg #(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              upd,
  input  logic              bad_c,
  input  logic [XLEN-1:0]   sum,
  input  logic [RIDX_W-1:0] base_idx,
  output logic              out_valid,
  output logic [XLEN-1:0]   ea,
  output logic              bad_form,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      ea        <= '0;
      bad_form  <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid && upd && !bad_c;
      if (in_valid) begin
        ea       <= sum;
        bad_form <= bad_c;
        wb_idx   <= base_idx;
        wb_data  <= sum;
      end
    end
  end

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wb_en && $stable(ea) && $stable(bad_form)));
  p_wb_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (out_valid && !bad_form && wb_data == ea));
endmodule

// File: rtl/load_ea_unit.sv
module load_ea_unit #(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        form_sel,
  input  logic              upd,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   idx_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [RIDX_W-1:0] tgt_idx,
  output logic              out_valid,
  output logic [XLEN-1:0]   ea,
  output logic              bad_form,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data
);
  lea_pkg::form_e  form;
  logic [XLEN-1:0] base_term, offset, sum;
  logic            zero_sub, pair_bad, upd_bad, bad_c;

  assign form = lea_pkg::form_e'(form_sel);

  lea_base_sel #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_base (
    .upd(upd), .base_idx(base_idx), .base_val(base_val),
    .base_term(base_term), .zero_sub(zero_sub));

  lea_offset #(.XLEN(XLEN), .DISP_W(DISP_W)) u_off (
    .form(form), .disp(disp), .idx_val(idx_val), .offset(offset));

  lea_form_check #(.RIDX_W(RIDX_W)) u_chk (
    .form(form), .upd(upd), .base_idx(base_idx), .tgt_idx(tgt_idx),
    .pair_bad(pair_bad), .upd_bad(upd_bad), .bad(bad_c));

  // Wraps modulo 2^XLEN; the carry is dropped (R11).
  assign sum = base_term + offset;

  lea_out_reg #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .upd(upd), .bad_c(bad_c),
    .sum(sum), .base_idx(base_idx), .out_valid(out_valid), .ea(ea),
    .bad_form(bad_form), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data));

  p_zero_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && zero_sub) |=> (ea == $past(offset)));
  p_pair_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form_sel == 2'd2 && tgt_idx[0]) |=> bad_form);
  p_upd_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && upd && (base_idx == '0 || base_idx == tgt_idx)) |=> (bad_form && !wb_en));
  p_upd_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && upd && !pair_bad && !upd_bad) |=> (wb_en && wb_idx == $past(base_idx)));
endmodule

// File: tb/tb_load_ea_unit.sv
module tb_load_ea_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic [1:0]  form;
    logic        upd;
    logic [4:0]  bidx;
    logic [63:0] bval;
    logic [63:0] ival;
    logic [15:0] disp;
    logic [4:0]  tidx;
    logic [63:0] exp_ea;
    logic        exp_bad;
    logic        exp_wb;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // R5 D form, positive displacement
    '{2'd0, 1'b0, 5'd3, 64'h1000, 64'h0, 16'h0010, 5'd4, 64'h1010, 1'b0, 1'b0, 8'd5},
    // R2 base register 0 reads as zero; displacement -1
    '{2'd0, 1'b0, 5'd0, 64'h5555, 64'h0, 16'hFFFF, 5'd4, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 8'd2},
    // R4 indexed form with base register 0
    '{2'd3, 1'b0, 5'd0, 64'h777, 64'h2000, 16'h0, 5'd4, 64'h2000, 1'b0, 1'b0, 8'd4},
    // R11 indexed sum wraps to zero
    '{2'd3, 1'b0, 5'd5, 64'h100, 64'hFFFF_FFFF_FFFF_FF00, 16'h0, 5'd4, 64'h0, 1'b0, 1'b0, 8'd11},
    // R6 DS form, upper disp bits ignored, offset 12
    '{2'd1, 1'b0, 5'd2, 64'h1000, 64'h0, 16'hC003, 5'd4, 64'h100C, 1'b0, 1'b0, 8'd6},
    // R6 DS form, negative field gives -4
    '{2'd1, 1'b0, 5'd2, 64'h1000, 64'h0, 16'h3FFF, 5'd4, 64'hFFC, 1'b0, 1'b0, 8'd6},
    // R7 DQ form, offset 32, even pair
    '{2'd2, 1'b0, 5'd3, 64'h2000, 64'h0, 16'hF002, 5'd6, 64'h2020, 1'b0, 1'b0, 8'd7},
    // R8 DQ odd target pair, disp -16
    '{2'd2, 1'b0, 5'd3, 64'h2000, 64'h0, 16'h0FFF, 5'd5, 64'h1FF0, 1'b1, 1'b0, 8'd8},
    // R8 DQ target pair equals base
    '{2'd2, 1'b0, 5'd4, 64'h40, 64'h0, 16'h0, 5'd4, 64'h40, 1'b1, 1'b0, 8'd8},
    // R10 D update, most negative displacement
    '{2'd0, 1'b1, 5'd7, 64'h3000, 64'h0, 16'h8000, 5'd1, 64'hFFFF_FFFF_FFFF_B000, 1'b0, 1'b1, 8'd10},
    // R3 update with base 0 uses contents; R9 flags it
    '{2'd3, 1'b1, 5'd0, 64'h900, 64'h10, 16'h0, 5'd4, 64'h910, 1'b1, 1'b0, 8'd3},
    // R9 update with base equal to target
    '{2'd3, 1'b1, 5'd6, 64'h10, 64'h20, 16'h0, 5'd6, 64'h30, 1'b1, 1'b0, 8'd9},
    // R10 DS update
    '{2'd1, 1'b1, 5'd9, 64'h100, 64'h0, 16'h0001, 5'd2, 64'h104, 1'b0, 1'b1, 8'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  form_sel = '0;
  logic        upd = 1'b0;
  logic [4:0]  base_idx = '0;
  logic [63:0] base_val = '0;
  logic [63:0] idx_val = '0;
  logic [15:0] disp = '0;
  logic [4:0]  tgt_idx = '0;
  logic        out_valid, bad_form, wb_en;
  logic [63:0] ea, wb_data;
  logic [4:0]  wb_idx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_ea_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form_sel(form_sel), .upd(upd),
    .base_idx(base_idx), .base_val(base_val), .idx_val(idx_val), .disp(disp),
    .tgt_idx(tgt_idx), .out_valid(out_valid), .ea(ea), .bad_form(bad_form),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    string r;
    r = $sformatf("R%0d", v.req);
    @(negedge clk);
    in_valid = 1'b1; form_sel = v.form; upd = v.upd; base_idx = v.bidx;
    base_val = v.bval; idx_val = v.ival; disp = v.disp; tgt_idx = v.tidx;
    @(negedge clk);
    in_valid = 1'b0;
    check(ea == v.exp_ea, r, "ea", ea, v.exp_ea);
    check(bad_form == v.exp_bad, r, "bad_form", 64'(bad_form), 64'(v.exp_bad));
    check(wb_en == v.exp_wb, r, "wb_en", 64'(wb_en), 64'(v.exp_wb));
    check(out_valid == 1'b1, "R12", "out_valid pulse", 64'(out_valid), 64'd1);
    if (v.exp_wb) begin
      check(wb_idx == v.bidx, r, "wb_idx", 64'(wb_idx), 64'(v.bidx));
      check(wb_data == v.exp_ea, r, "wb_data", wb_data, v.exp_ea);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1", "out_valid", 64'(out_valid), 64'd0);
    check(wb_en == 1'b0, "R1", "wb_en", 64'(wb_en), 64'd0);
    check(bad_form == 1'b0, "R1", "bad_form", 64'(bad_form), 64'd0);
    check(ea == 64'd0, "R1", "ea", ea, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R12 hold: after an update result, idle cycles with changed inputs
    run_vec(VECS[9]);
    base_val = 64'hDEAD; disp = 16'h1234; upd = 1'b1; base_idx = 5'd2; tgt_idx = 5'd3;
    @(negedge clk);
    check(out_valid == 1'b0, "R12", "idle out_valid", 64'(out_valid), 64'd0);
    check(wb_en == 1'b0, "R12", "idle wb_en", 64'(wb_en), 64'd0);
    check(ea == 64'hFFFF_FFFF_FFFF_B000, "R12", "idle ea hold", ea, 64'hFFFF_FFFF_FFFF_B000);
    @(negedge clk);
    check(ea == 64'hFFFF_FFFF_FFFF_B000, "R12", "idle ea hold 2", ea, 64'hFFFF_FFFF_FFFF_B000);
    check(bad_form == 1'b0, "R12", "idle bad hold", 64'(bad_form), 64'd0);

    // R2 same request with another base_val gives the same address
    run_vec('{2'd0, 1'b0, 5'd0, 64'hFFFF_0000_1234_5678, 64'h0, 16'h0020, 5'd4, 64'h20, 1'b0, 1'b0, 8'd2});
    // R11 D-form wrap at the top of the address space
    run_vec('{2'd0, 1'b0, 5'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 16'h0020, 5'd4, 64'h10, 1'b0, 1'b0, 8'd11});

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule